// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block loads configuration data into a programmable target device over a passive serial link. It pulls bytes from a ready/valid byte stream, usually the output of a flash reader, and sends each byte out one bit at a time on a single data line. The block also drives the serial clock that goes with the data line. Before any data moves, it runs the target's reset handshake. It pulls the active-low configuration request line low for a fixed minimum time, releases it, and waits for the target's open-drain status line to go high. Only then does it start shifting.

After the byte marked last has been sent, the block keeps the serial clock running so the target can finish initialization. It stops when the target's configuration-done line rises. Both target lines are synchronized before use. Toward the local side, the block reports busy, done and error, and gives a two-bit code that tells the three failures apart. A start pulse in the idle, done or error state begins a new cycle. A start pulse while busy has no effect.

Top module: `psc_host`

## Requirements
- R1: After the synchronous reset, `cfg_req_n` is 1, `dclk` is 0, `s_ready` is 0, and `busy`, `done`, `err` and `err_code` are all 0.
- R2: A `start` pulse while idle, done or in error sets `busy` and drives `cfg_req_n` low for exactly REQ_LOW_CYC clocks before releasing it. A `start` pulse while busy is ignored and does not pull `cfg_req_n` low again.
- R3: No rising edge of `dclk` occurs and `s_ready` stays 0 while `cfg_req_n` is low, and also until `status_n` has been seen high after the release.
- R4: If `status_n` is not seen high within STAT_WAIT_CYC clocks after the release, the block stops with `err`=1 and `err_code`=1 (status timeout). `err_code` is 0 whenever `err` is 0.
- R5: Each byte is sent least-significant bit first, with one bit per rising edge of `dclk` and exactly 8 rising edges per byte. `dout` does not change while `dclk` is high.
- R6: A byte is taken when `s_valid` and `s_ready` are both 1 on a clock edge. `s_ready` is 1 only in the shift phase, when no byte is being held and the last byte has not yet been taken. While no byte is available, `dclk` stays low. The serial bit stream equals the accepted bytes exactly, with no bits lost or added.
- R7: If `status_n` is seen low during shifting or initialization, the block stops with `err`=1 and `err_code`=2. After that, `dclk` and `s_ready` stay 0.
- R8: Once the byte with `s_last`=1 has been sent, `dclk` toggles freely until `conf_done` is seen high. The block then shows `done`=1 and `busy`=0, and `dclk` stays low. At most one of `busy`, `done` and `err` is 1 at any time.
- R9: If `conf_done` is not seen high within INIT_EXTRA_CLK rising edges of `dclk` after the last data bit, the block stops with `err`=1 and `err_code`=3 (done timeout). Exactly INIT_EXTRA_CLK extra rising edges are produced.
- R10: A `start` pulse after an error or after completion runs a full new configuration cycle. That cycle reaches `done` when the target behaves correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration cycle (one-clock pulse) |
| busy | output | 1 | A configuration cycle is in progress |
| done | output | 1 | Last cycle finished with the target reporting done |
| err | output | 1 | Last cycle stopped on a failure |
| err_code | output | 2 | 0 none, 1 status timeout, 2 status lost, 3 done timeout |
| s_data | input | DATA_W | Configuration byte |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | This byte is the final one |
| s_ready | output | 1 | Block accepts a byte this clock |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| dclk | output | 1 | Serial clock to the target |
| dout | output | 1 | Serial data to the target |
| status_n | input | 1 | Target status line (open-drain, undriven reads high) |
| conf_done | input | 1 | Target configuration-done line (open-drain) |

## Verification
The serial path is tested with several kinds of byte stream. The first is back-to-back bytes, which shows whether bytes are joined together with no missing or extra bits. The second uses long gaps between bytes, which shows whether the clock parks low and resumes without losing a bit. The third includes the values 0x01 and 0x80, which would expose a reversed bit order. The target model's status and done lines are driven in several ways: a normal release, a status line stuck low, status dropping in the middle of a byte, and a done line that never rises. Each of these separates one of the three error codes from normal completion. Restarts from both the done state and the error state check that no state is left over from the previous cycle.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SHIFT,
    ST_INIT,
    ST_DONE,
    ST_FAIL
  } psc_state_e;

  typedef enum logic [1:0] {
    ERR_NONE        = 2'd0,
    ERR_STATUS_TO   = 2'd1,
    ERR_STATUS_LOST = 2'd2,
    ERR_DONE_TO     = 2'd3
  } psc_err_e;

endpackage

// File: rtl/psc_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for an asynchronous target line.
module psc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= RST_VAL;
        else     pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/psc_shift.sv
`timescale 1ns/1ps
// Byte-to-serial converter with a host-generated clock.
// One bit takes two system clocks: data set up with dclk low, then dclk high.
module psc_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         flush,
  input  logic [W-1:0] s_data,
  input  logic         s_valid,
  input  logic         s_last,
  output logic         s_ready,
  output logic         dclk,
  output logic         dout,
  output logic         last_sent,
  output logic         tick
);

  localparam int BCW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]   sh_q;
  logic [BCW-1:0] bcnt_q;
  logic           loaded_q;
  logic           last_q;
  logic           fin_q;
  logic           dclk_q;
  logic           dout_q;
  logic           last_sent_q;
  logic           tick_q;

  assign s_ready = run && !loaded_q && !fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      bcnt_q      <= '0;
      loaded_q    <= 1'b0;
      last_q      <= 1'b0;
      fin_q       <= 1'b0;
      dclk_q      <= 1'b0;
      dout_q      <= 1'b0;
      last_sent_q <= 1'b0;
      tick_q      <= 1'b0;
    end else begin
      last_sent_q <= 1'b0;
      tick_q      <= 1'b0;
      if (run) begin
        if (!loaded_q) begin
          dclk_q <= 1'b0;
          if (s_valid && !fin_q) begin
            sh_q     <= s_data;
            dout_q   <= s_data[0];
            bcnt_q   <= '0;
            loaded_q <= 1'b1;
            last_q   <= s_last;
            fin_q    <= s_last;
          end
        end else if (!dclk_q) begin
          dclk_q <= 1'b1;
        end else begin
          dclk_q <= 1'b0;
          if (bcnt_q == BCW'(W-1)) begin
            loaded_q    <= 1'b0;
            last_sent_q <= last_q;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
            sh_q   <= sh_q >> 1;
            dout_q <= sh_q[1];
          end
        end
      end else if (flush) begin
        dclk_q   <= !dclk_q;
        tick_q   <= !dclk_q;
        loaded_q <= 1'b0;
      end else begin
        dclk_q   <= 1'b0;
        loaded_q <= 1'b0;
        fin_q    <= 1'b0;
      end
    end
  end

  assign dclk      = dclk_q;
  assign dout      = dout_q;
  assign last_sent = last_sent_q;
  assign tick      = tick_q;

endmodule

// File: rtl/psc_seq.sv
`timescale 1ns/1ps
// Reset / configuration / initialization sequencer with one shared counter.
module psc_seq
  import psc_pkg::*;
#(
  parameter int REQ_LOW_CYC    = 8,
  parameter int STAT_WAIT_CYC  = 256,
  parameter int INIT_EXTRA_CLK = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       status_ok,
  input  logic       done_ok,
  input  logic       last_sent,
  input  logic       tick,
  output psc_state_e state,
  output logic       cfg_req_n,
  output logic       run,
  output logic       flush,
  output psc_err_e   err_code
);

  localparam int MAX_AB = (REQ_LOW_CYC > STAT_WAIT_CYC) ? REQ_LOW_CYC : STAT_WAIT_CYC;
  localparam int MAXC   = (MAX_AB > INIT_EXTRA_CLK) ? MAX_AB : INIT_EXTRA_CLK;
  localparam int CW     = $clog2(MAXC + 1);

  psc_state_e state_q;
  psc_err_e   code_q;
  logic [CW-1:0] cnt_q;
  logic          req_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      code_q  <= ERR_NONE;
      cnt_q   <= '0;
      req_n_q <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start) begin
            state_q <= ST_REQ;
            code_q  <= ERR_NONE;
            req_n_q <= 1'b0;
            cnt_q   <= CW'(REQ_LOW_CYC - 1);
          end
        end
        ST_REQ: begin
          if (cnt_q == '0) begin
            req_n_q <= 1'b1;
            state_q <= ST_WAIT;
            cnt_q   <= CW'(STAT_WAIT_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (status_ok) begin
            state_q <= ST_SHIFT;
          end else if (cnt_q == '0) begin
            state_q <= ST_FAIL;
            code_q  <= ERR_STATUS_TO;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!status_ok) begin
            state_q <= ST_FAIL;
            code_q  <= ERR_STATUS_LOST;
          end else if (last_sent) begin
            state_q <= ST_INIT;
            cnt_q   <= CW'(INIT_EXTRA_CLK - 1);
          end
        end
        ST_INIT: begin
          if (!status_ok) begin
            state_q <= ST_FAIL;
            code_q  <= ERR_STATUS_LOST;
          end else if (done_ok) begin
            state_q <= ST_DONE;
          end else if (tick) begin
            if (cnt_q == '0) begin
              state_q <= ST_FAIL;
              code_q  <= ERR_DONE_TO;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state     = state_q;
  assign err_code  = code_q;
  assign cfg_req_n = req_n_q;
  assign run       = (state_q == ST_SHIFT);
  assign flush     = (state_q == ST_INIT);

endmodule

// File: rtl/psc_host.sv
`timescale 1ns/1ps
// Passive serial configuration host: top level.
module psc_host
  import psc_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int REQ_LOW_CYC    = 8,
  parameter int STAT_WAIT_CYC  = 256,
  parameter int INIT_EXTRA_CLK = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              cfg_req_n,
  output logic              dclk,
  output logic              dout,
  input  logic              status_n,
  input  logic              conf_done
);

  psc_state_e state;
  psc_err_e   code;
  logic status_ok;
  logic done_ok;
  logic run;
  logic flush;
  logic last_sent;
  logic tick;

  psc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_status (
    .clk (clk),
    .rst (rst),
    .d   (status_n),
    .q   (status_ok)
  );

  psc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk (clk),
    .rst (rst),
    .d   (conf_done),
    .q   (done_ok)
  );

  psc_seq #(
    .REQ_LOW_CYC    (REQ_LOW_CYC),
    .STAT_WAIT_CYC  (STAT_WAIT_CYC),
    .INIT_EXTRA_CLK (INIT_EXTRA_CLK)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .status_ok (status_ok),
    .done_ok   (done_ok),
    .last_sent (last_sent),
    .tick      (tick),
    .state     (state),
    .cfg_req_n (cfg_req_n),
    .run       (run),
    .flush     (flush),
    .err_code  (code)
  );

  psc_shift #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .flush     (flush),
    .s_data    (s_data),
    .s_valid   (s_valid),
    .s_last    (s_last),
    .s_ready   (s_ready),
    .dclk      (dclk),
    .dout      (dout),
    .last_sent (last_sent),
    .tick      (tick)
  );

  assign busy     = (state == ST_REQ) || (state == ST_WAIT) ||
                    (state == ST_SHIFT) || (state == ST_INIT);
  assign done     = (state == ST_DONE);
  assign err      = (state == ST_FAIL);
  assign err_code = code;

endmodule

// File: rtl/psc_host_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the configuration host.
module psc_host_chk #(
  parameter int REQ_LOW_CYC = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       s_ready,
  input logic       cfg_req_n,
  input logic       dclk,
  input logic       dout
);

  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst)             low_run <= 0;
    else if (!cfg_req_n) low_run <= (low_run < 32'hFFFF_0000) ? low_run + 1 : low_run;
    else                 low_run <= 0;
  end

  AST_REQ_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req_n) |-> (low_run == REQ_LOW_CYC)); // R2

  AST_DCLK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    dclk |-> cfg_req_n); // R3

  AST_CODE_ONLY_ERR: assert property (@(posedge clk) disable iff (rst)
    !err |-> (err_code == 2'd0)); // R4

  AST_DOUT_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    dclk |-> $stable(dout)); // R5

  AST_READY_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (busy && cfg_req_n && !err)); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, done, err})); // R8

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !dclk); // R8

endmodule

bind psc_host psc_host_chk #(.REQ_LOW_CYC(REQ_LOW_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .err_code  (err_code),
  .s_ready   (s_ready),
  .cfg_req_n (cfg_req_n),
  .dclk      (dclk),
  .dout      (dout)
);

// File: tb/psc_host_tb_top.sv
`timescale 1ns/1ps
module psc_host_tb_top;

  localparam int REQ_LOW  = 8;
  localparam int STAT_W   = 64;
  localparam int INIT_X   = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic       busy, done, err;
  logic [1:0] err_code;
  logic [7:0] s_data;
  logic       s_valid, s_last, s_ready;
  logic       cfg_req_n, dclk, dout;
  logic       status_n, conf_done;

  int vectors = 0;
  int fails   = 0;

  bit exp_q[$];
  int done_at  = 1 << 30;
  int rises_run = 0;
  int req_falls = 0;
  int last_low  = 0;
  int r3_viol   = 0;
  bit stuck = 1'b0;
  bit fault = 1'b0;
  bit drv_busy = 1'b0;

  always #2 clk = ~clk;

  psc_host #(
    .DATA_W(8), .REQ_LOW_CYC(REQ_LOW), .STAT_WAIT_CYC(STAT_W),
    .INIT_EXTRA_CLK(INIT_X), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .cfg_req_n(cfg_req_n), .dclk(dclk), .dout(dout),
    .status_n(status_n), .conf_done(conf_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // Target model: status held low during request and for a while after it,
  // done rises after a set number of serial clock edges.
  initial begin
    int hold = 20;
    bit prev = 1'b0;
    status_n  = 1'b0;
    conf_done = 1'b0;
    forever begin
      @(negedge clk);
      if (dclk === 1'b1 && !prev) rises_run++;
      prev = (dclk === 1'b1);
      if (cfg_req_n === 1'b0) begin
        hold = 12; status_n = 1'b0; rises_run = 0; conf_done = 1'b0;
      end else begin
        if (hold > 0) begin hold--; status_n = 1'b0; end
        else status_n = !(stuck || fault);
        conf_done = (rises_run >= done_at);
      end
    end
  end

  // Monitor / scoreboard: pops expected bits on each serial clock rise.
  initial begin
    bit mprev = 1'b0;
    bit rprev = 1'b1;
    int lowrun = 0;
    forever begin
      @(negedge clk);
      if (rst !== 1'b0) begin
        mprev = 1'b0; rprev = 1'b1; lowrun = 0;
      end else begin
        if (dclk && !mprev) begin
          if (!cfg_req_n || (!status_n && !fault)) r3_viol++;
          if (exp_q.size() > 0) begin
            bit b;
            b = exp_q.pop_front();
            chk(dout == b, "R5 serial bit order", {31'd0, dout}, {31'd0, b});
          end
        end
        if (s_ready && (!cfg_req_n || (!status_n && !fault))) r3_viol++;
        if (!cfg_req_n && rprev) req_falls++;
        if (!cfg_req_n) lowrun++;
        else if (lowrun > 0) begin last_low = lowrun; lowrun = 0; end
        mprev = dclk;
        rprev = cfg_req_n;
      end
    end
  end

  function automatic logic [7:0] pick(input int i, input int seed);
    if (i == 0) return 8'h01;
    if (i == 1) return 8'h80;
    return 8'((i * 53 + seed * 29) ^ 8'h5A);
  endfunction

  task automatic send_bytes(input int n, input int seed, input bit gappy);
    drv_busy = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      if (err) break;
      d = pick(i, seed);
      @(negedge clk);
      s_data = d; s_last = (i == n - 1); s_valid = 1'b1;
      while (!s_ready && !err) @(negedge clk);
      if (err) break;
      for (int k = 0; k < 8; k++) exp_q.push_back(d[k]);
      @(posedge clk);
      if (gappy && (i % 2 == 0) && (i < n - 1)) begin
        @(negedge clk);
        s_valid = 1'b0;
        repeat (24) @(negedge clk);
        chk(!dclk && s_ready, "R6 clock parked low while no byte", {30'd0, dclk, s_ready}, 32'd1);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    drv_busy = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    int c = 0;
    while (!done && !err && c < lim) begin @(negedge clk); c++; end
  endtask

  task automatic kick(input int n, input int extra);
    exp_q.delete();
    done_at = n * 8 + extra;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !cfg_req_n, "R2 request driven low after start", {30'd0, busy, cfg_req_n}, 32'd2);
  endtask

  task automatic expect_done(input string tag);
    chk(done && !err && !busy, tag, {29'd0, busy, done, err}, 32'd2);
    chk(err_code == 2'd0, "R4 code zero on success", {30'd0, err_code}, 32'd0);
    chk(exp_q.size() == 0, "R6 every accepted bit sent", exp_q.size(), 32'd0);
    repeat (4) @(negedge clk);
    chk(!dclk, "R8 clock quiet after done", {31'd0, dclk}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    int base, falls0;
    rst = 1'b1; start = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_data = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cfg_req_n && !dclk && !s_ready, "R1 reset line levels", {29'd0, cfg_req_n, dclk, s_ready}, 32'd4);
    chk(!busy && !done && !err && err_code == 2'd0, "R1 reset flags",
        {27'd0, busy, done, err, err_code}, 32'd0);
    repeat (30) @(negedge clk);

    // Test 1: back-to-back bytes; hold-off while status low (R3)
    kick(4, 3);
    repeat (12) @(negedge clk);
    chk(!s_ready && !dclk, "R3 no shifting before status release", {30'd0, s_ready, dclk}, 32'd0);
    send_bytes(4, 1, 1'b0);
    wait_end(3000);
    expect_done("R8 done after back-to-back stream");
    chk(last_low == REQ_LOW, "R2 request low width", last_low, REQ_LOW);

    // Test 2: gappy stream, restart from done, start while busy ignored (R10, R2, R6)
    falls0 = req_falls;
    kick(5, 6);
    fork
      begin
        repeat (60) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    join_none
    send_bytes(5, 7, 1'b1);
    wait_end(3000);
    expect_done("R10 restart from done completes");
    chk(req_falls - falls0 == 1, "R2 start while busy ignored", req_falls - falls0, 32'd1);

    // Test 3: status stuck low -> status timeout (R4)
    stuck = 1'b1;
    kick(2, 3);
    wait_end(500);
    chk(err && err_code == 2'd1, "R4 status timeout code", {29'd0, err, err_code}, 32'd5);
    chk(!busy && !dclk && !s_ready, "R4 idle lines after timeout", {29'd0, busy, dclk, s_ready}, 32'd0);
    chk(rises_run == 0, "R3 no clock edges while status low", rises_run, 32'd0);
    stuck = 1'b0;

    // Test 4: restart after error (R10)
    kick(2, 2);
    send_bytes(2, 3, 1'b0);
    wait_end(3000);
    expect_done("R10 restart from error completes");

    // Test 5: status lost mid-byte (R7)
    kick(6, 3);
    drv_busy = 1'b1;
    fork
      send_bytes(6, 5, 1'b0);
    join_none
    base = 0;
    while (rises_run < 11 && base < 2000) begin @(negedge clk); base++; end
    fault = 1'b1;
    wait_end(200);
    chk(err && err_code == 2'd2, "R7 status lost code", {29'd0, err, err_code}, 32'd6);
    repeat (3) @(negedge clk);
    chk(!dclk && !s_ready, "R7 lines idle after status loss", {30'd0, dclk, s_ready}, 32'd0);
    fault = 1'b0;
    base = 0;
    while (drv_busy && base < 2000) begin @(negedge clk); base++; end
    exp_q.delete();

    // Test 6: done never rises -> done timeout, exact extra edges (R9)
    kick(2, 1 << 20);
    send_bytes(2, 9, 1'b0);
    wait_end(3000);
    chk(err && err_code == 2'd3, "R9 done timeout code", {29'd0, err, err_code}, 32'd7);
    repeat (4) @(negedge clk);
    chk(rises_run == 16 + INIT_X, "R9 extra clock edge count", rises_run, 16 + INIT_X);

    // Test 7: restart after done timeout (R10)
    kick(3, 4);
    send_bytes(3, 11, 1'b0);
    wait_end(3000);
    expect_done("R10 restart after done timeout");

    chk(r3_viol == 0, "R3 clock or ready seen during target reset", r3_viol, 32'd0);
    summary();
    $finish;
  end

endmodule